// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the processor-side register window of a small telephony and audio controller. The processor sees eight byte-wide locations selected by a 3-bit address, with separate read and write strobes. Location 0 has two meanings. A write to it loads a register number into a pointer, and a read of it returns and clears the pending interrupt sources. Location 1 is the data window into the register that the pointer selects. Locations 2 to 7 pass read-only status bytes and channel buffer bytes between the processor and the surrounding engines.

The registers behind the pointer hold the device mode and interrupt mask, a channel-routing byte, a B-channel control byte, a codec configuration byte and a 16-bit gain coefficient. Each write to the pointer restarts a byte index. Every access to the data window then moves to the next byte, so a wide register is filled or read in a single burst. Eight event pulses from the line, link and codec engines are collected into a sticky pending mask, and a single interrupt line reports that mask.

Top module: `ireg_port`

## Requirements
- R1: After reset, `rdData` is 0x00 and `irqOut` is low. `devMode` is 0 (idle), `txStb` is 0, `gainCoef` is 0 and every other configuration output is 0.
- R2: A read of location 2, 3, 4, 5, 6 or 7 returns `stat1In`, `errIn`, `rxDIn`, `rxBbIn`, `rxBcIn` or `stat2In`, in that address order. A write to location 4, 5 or 6 sets `txStb` bit 0, 1 or 2 for exactly one cycle, starting the cycle after the write, and `txByte` carries the written byte.
- R3: Read data appears on `rdData` in the cycle after `rdEn` and holds until the next read. A write to location 0 selects the register whose number is written and sets the byte index to 0. Each read or write of location 1 accesses the byte at the current index and then advances the index.
- R4: Register 0x63 is a 16-bit gain coefficient. After a pointer write, the first data write loads bits 7:0 and the second loads bits 15:8. Reads return the bytes in the same order, and the value is driven on `gainCoef`.
- R5: A data access whose index is past the selected register's width does not change it on a write and returns 0x00 on a read. This applies to the third byte of register 0x63 and to the second byte of any one-byte register.
- R6: Register 0x21 controls the device. Bits 1:0 give the mode on `devMode`: 0 is idle, 1 is active, 2 is data-only and 3 is power-down. Bit 2 drives `intMask`. A read returns these three bits, with bits 7:3 reading 0.
- R7: In register 0x44, bit 3 drives `bIntEn`, bit 4 drives `revBb` and bit 5 drives `revBc`. All other bits read back as 0.
- R8: Register 0x41 drives `muxSrc` from bits 3:0 and `muxDst` from bits 7:4. Both are 4-bit channel codes: 1 to 8 stand for channels B1, B2, Ba, Bb, Bc, Bd, Be and Bf.
- R9: Register 0x69 is a full byte driven on `mapCtl`. Its bit 0 also drives `aLaw` (1 selects A-law and 0 selects mu-law), and bit 7 is the loopback enable.
- R10: A read of location 0 returns the pending mask and clears it. Pending bit k is set by a pulse on `evtIn[k]`. The bits are: 0 D transmit threshold, 1 D receive threshold, 2 D packet status, 3 D error, 4 B-channel byte, 5 line status, 6 D buffer status, 7 multiframe/peripheral. An event that arrives in the same cycle as the clearing read is not returned by that read, and it stays pending.
- R11: A pulse on `evtIn[4]` is recorded only while `bIntEn` is 1.
- R12: `irqOut` is high when any pending bit is set. It is held low while `intMask` is 1 or `devMode` is 0, and pending bits are kept while it is held low.
- R13: Any register number other than 0x21, 0x41, 0x44, 0x63 and 0x69 reads as 0x00, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Window location |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| evtIn | input | 8 | Interrupt event pulses |
| stat1In | input | 8 | Link status byte 1 |
| errIn | input | 8 | Link error byte |
| stat2In | input | 8 | Link status byte 2 |
| rxDIn | input | 8 | D-channel receive byte |
| rxBbIn | input | 8 | Bb-channel receive byte |
| rxBcIn | input | 8 | Bc-channel receive byte |
| txStb | output | 3 | Transmit byte strobes: bit 0 D, bit 1 Bb, bit 2 Bc |
| txByte | output | 8 | Transmit byte |
| irqOut | output | 1 | Interrupt request |
| devMode | output | 2 | Device mode |
| intMask | output | 1 | Global interrupt mask |
| bIntEn | output | 1 | B-channel event enable |
| revBb | output | 1 | Bb bit-order reversal |
| revBc | output | 1 | Bc bit-order reversal |
| muxSrc | output | 4 | Routing source channel code |
| muxDst | output | 4 | Routing destination channel code |
| aLaw | output | 1 | Companding law select |
| mapCtl | output | 8 | Codec configuration byte |
| gainCoef | output | 16 | Gain coefficient |

## Verification
The pointer-and-data sequence is tested with several bursts: a two-byte load and read-back of the gain register, a burst that runs past the end of that register, a second byte sent to a one-byte register, and accesses to a register number that does not exist. Together these show whether the index restarts on each pointer write, whether it advances on both reads and writes, and whether out-of-range bytes are dropped. The interrupt path is tested three ways: with an event that arrives on its own, with an event that lands in the same cycle as the clearing read, and with the B-channel event while its enable is clear. The interrupt line is also checked under each of the mask and idle gates. These cases separate a correct read-clear ordering from a clear that loses a new event, and they show whether gating holds the pending state or throws it away.

// File: rtl/ireg_port_pkg.sv
package ireg_port_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int NUM_EVT    = 8;
  localparam int NUM_BUF    = 3;
  localparam int GAIN_BYTES = 2;
  localparam int GAIN_W     = GAIN_BYTES * DATA_W;
  localparam int IDX_W      = $clog2(GAIN_BYTES + 1);
  localparam int B_EVT_BIT  = 4;

  localparam logic [DATA_W-1:0] RN_INIT = 8'h21;
  localparam logic [DATA_W-1:0] RN_MUX  = 8'h41;
  localparam logic [DATA_W-1:0] RN_ENAB = 8'h44;
  localparam logic [DATA_W-1:0] RN_GAIN = 8'h63;
  localparam logic [DATA_W-1:0] RN_MAP  = 8'h69;

  localparam logic [ADDR_W-1:0] LOC_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] LOC_DATA = 3'd1;
  localparam int                LOC_BUF0 = 4;

  typedef struct packed {
    logic                 cmdWr;
    logic                 dataWr;
    logic                 dataRd;
    logic                 irqRd;
    logic                 rdAny;
    logic [NUM_BUF-1:0]   bufWr;
    logic [ADDR_W-1:0]    rdAddr;
    logic [DATA_W-1:0]    regNum;
    logic [IDX_W-1:0]     byteIdx;
  } ctlStrb_t;
endpackage

// File: rtl/ireg_port_ctl.sv
module ireg_port_ctl
  import ireg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrb_t          strb
);
  logic [DATA_W-1:0] regNum;
  logic [IDX_W-1:0]  byteIdx;
  logic              dataAcc;

  always_comb begin
    strb.cmdWr   = wrEn && (addr == LOC_CMD);
    strb.dataWr  = wrEn && (addr == LOC_DATA);
    strb.dataRd  = rdEn && (addr == LOC_DATA);
    strb.irqRd   = rdEn && (addr == LOC_CMD);
    strb.rdAny   = rdEn;
    strb.rdAddr  = addr;
    strb.regNum  = regNum;
    strb.byteIdx = byteIdx;
    for (int i = 0; i < NUM_BUF; i++)
      strb.bufWr[i] = wrEn && (addr == ADDR_W'(LOC_BUF0 + i));
  end

  assign dataAcc = strb.dataWr || strb.dataRd;

  // The index stops one step past the widest register, so any further
  // access also falls outside every register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regNum  <= '0;
      byteIdx <= '0;
    end else if (strb.cmdWr) begin
      regNum  <= wrData;
      byteIdx <= '0;
    end else if (dataAcc && byteIdx != IDX_W'(GAIN_BYTES)) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end
endmodule

// File: rtl/ireg_port_dp.sv
module ireg_port_dp
  import ireg_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrb_t           strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [DATA_W-1:0]  stat1In,
  input  logic [DATA_W-1:0]  errIn,
  input  logic [DATA_W-1:0]  stat2In,
  input  logic [DATA_W-1:0]  rxDIn,
  input  logic [DATA_W-1:0]  rxBbIn,
  input  logic [DATA_W-1:0]  rxBcIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_BUF-1:0] txStb,
  output logic [DATA_W-1:0]  txByte,
  output logic               irqOut,
  output logic [1:0]         devMode,
  output logic               intMask,
  output logic               bIntEn,
  output logic               revBb,
  output logic               revBc,
  output logic [3:0]         muxSrc,
  output logic [3:0]         muxDst,
  output logic               aLaw,
  output logic [DATA_W-1:0]  mapCtl,
  output logic [GAIN_W-1:0]  gainCoef
);
  logic [2:0]         initR;
  logic [DATA_W-1:0]  muxR;
  logic [2:0]         enabR;
  logic [DATA_W-1:0]  mapR;
  logic [GAIN_W-1:0]  gainR;
  logic [NUM_EVT-1:0] pending;
  logic [NUM_EVT-1:0] evtKeep;
  logic [DATA_W-1:0]  indVal;
  logic [DATA_W-1:0]  rdMux;
  logic               firstByte;

  assign firstByte = (strb.byteIdx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initR <= '0;
      muxR  <= '0;
      enabR <= '0;
      mapR  <= '0;
    end else if (strb.dataWr && firstByte) begin
      case (strb.regNum)
        RN_INIT: initR <= wrData[2:0];
        RN_MUX:  muxR  <= wrData;
        RN_ENAB: enabR <= wrData[5:3];
        RN_MAP:  mapR  <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < GAIN_BYTES; g++) begin : g_gain
    logic [DATA_W-1:0] byteQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byteQ <= '0;
      else if (strb.dataWr && strb.regNum == RN_GAIN && strb.byteIdx == IDX_W'(g))
        byteQ <= wrData;
    end
    assign gainR[g*DATA_W +: DATA_W] = byteQ;
  end

  always_comb begin
    indVal = '0;
    case (strb.regNum)
      RN_INIT: if (firstByte) indVal = {5'b0, initR};
      RN_MUX:  if (firstByte) indVal = muxR;
      RN_ENAB: if (firstByte) indVal = {2'b0, enabR, 3'b0};
      RN_MAP:  if (firstByte) indVal = mapR;
      RN_GAIN: indVal = DATA_W'(gainR >> (DATA_W * int'(strb.byteIdx)));
      default: ;
    endcase
  end

  always_comb begin
    case (strb.rdAddr)
      3'd0:    rdMux = pending;
      3'd1:    rdMux = indVal;
      3'd2:    rdMux = stat1In;
      3'd3:    rdMux = errIn;
      3'd4:    rdMux = rxDIn;
      3'd5:    rdMux = rxBbIn;
      3'd6:    rdMux = rxBcIn;
      default: rdMux = stat2In;
    endcase
  end

  always_comb begin
    evtKeep = evtIn;
    if (!enabR[0]) evtKeep[B_EVT_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      pending <= '0;
      txStb   <= '0;
      txByte  <= '0;
    end else begin
      if (strb.rdAny) rdData <= rdMux;
      // A new event is merged after the clear, so it survives the read.
      pending <= (strb.irqRd ? '0 : pending) | evtKeep;
      txStb   <= strb.bufWr;
      if (|strb.bufWr) txByte <= wrData;
    end
  end

  assign devMode  = initR[1:0];
  assign intMask  = initR[2];
  assign irqOut   = (|pending) && !initR[2] && (initR[1:0] != 2'd0);
  assign bIntEn   = enabR[0];
  assign revBb    = enabR[1];
  assign revBc    = enabR[2];
  assign muxSrc   = muxR[3:0];
  assign muxDst   = muxR[7:4];
  assign aLaw     = mapR[0];
  assign mapCtl   = mapR;
  assign gainCoef = gainR;
endmodule

// File: rtl/ireg_port.sv
module ireg_port
  import ireg_port_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   addr,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [7:0]   wrData,
  output logic [7:0]   rdData,
  input  logic [7:0]   evtIn,
  input  logic [7:0]   stat1In,
  input  logic [7:0]   errIn,
  input  logic [7:0]   stat2In,
  input  logic [7:0]   rxDIn,
  input  logic [7:0]   rxBbIn,
  input  logic [7:0]   rxBcIn,
  output logic [2:0]   txStb,
  output logic [7:0]   txByte,
  output logic         irqOut,
  output logic [1:0]   devMode,
  output logic         intMask,
  output logic         bIntEn,
  output logic         revBb,
  output logic         revBc,
  output logic [3:0]   muxSrc,
  output logic [3:0]   muxDst,
  output logic         aLaw,
  output logic [7:0]   mapCtl,
  output logic [15:0]  gainCoef
);
  ctlStrb_t strb;

  ireg_port_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .strb   (strb)
  );

  ireg_port_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .evtIn    (evtIn),
    .stat1In  (stat1In),
    .errIn    (errIn),
    .stat2In  (stat2In),
    .rxDIn    (rxDIn),
    .rxBbIn   (rxBbIn),
    .rxBcIn   (rxBcIn),
    .rdData   (rdData),
    .txStb    (txStb),
    .txByte   (txByte),
    .irqOut   (irqOut),
    .devMode  (devMode),
    .intMask  (intMask),
    .bIntEn   (bIntEn),
    .revBb    (revBb),
    .revBc    (revBc),
    .muxSrc   (muxSrc),
    .muxDst   (muxDst),
    .aLaw     (aLaw),
    .mapCtl   (mapCtl),
    .gainCoef (gainCoef)
  );
endmodule

// File: rtl/ireg_port_chk.sv
module ireg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  wrData,
  input logic [7:0]  evtIn,
  input logic [2:0]  txStb,
  input logic [7:0]  txByte,
  input logic        irqOut,
  input logic [1:0]  devMode,
  input logic        intMask,
  input logic        bIntEn,
  input logic        revBb,
  input logic        revBc,
  input logic [3:0]  muxSrc,
  input logic [3:0]  muxDst,
  input logic        aLaw,
  input logic [7:0]  mapCtl,
  input logic [15:0] gainCoef
);
  // R2: a D-buffer write yields a single strobe carrying that byte
  a_r2_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == 3'd4) |=> (txStb == 3'b001 && txByte == $past(wrData)));

  // R2: no write, no strobe
  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> (txStb == 3'b000));

  // R10: a clearing read with no new event drops the request
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && addr == 3'd0 && evtIn == 8'h00) |=> !irqOut);

  // R10: an event on bit 0 raises the request when ungated
  a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evtIn[0] && !wrEn && !intMask && devMode != 2'd0) |=> irqOut);

  // R11: a B-channel event alone leaves an idle request low while disabled
  a_r11_bevent_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqOut && !intMask && devMode != 2'd0 && evtIn == 8'h10 && !bIntEn && !wrEn)
      |=> !irqOut);

  // R12: mask or idle forces the request low
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (intMask || devMode == 2'd0) |-> !irqOut);

  // R13: configuration only changes after a write
  a_r13_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable({gainCoef, mapCtl, aLaw, muxSrc, muxDst, revBb, revBc,
                       bIntEn, intMask, devMode}));
endmodule

bind ireg_port ireg_port_chk u_chk (.*);

// File: tb/ireg_port_bench.sv
module ireg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  evtIn = '0;
  logic [7:0]  stat1In = 8'hA1;
  logic [7:0]  errIn = 8'hB2;
  logic [7:0]  stat2In = 8'hC3;
  logic [7:0]  rxDIn = 8'hD4;
  logic [7:0]  rxBbIn = 8'hE5;
  logic [7:0]  rxBcIn = 8'hF6;
  logic [2:0]  txStb;
  logic [7:0]  txByte;
  logic        irqOut;
  logic [1:0]  devMode;
  logic        intMask, bIntEn, revBb, revBc, aLaw;
  logic [3:0]  muxSrc, muxDst;
  logic [7:0]  mapCtl;
  logic [15:0] gainCoef;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic rdSeen = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  ireg_port u_ireg_port (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdEvt(input logic [2:0] a, input logic [7:0] ev,
                       input logic [7:0] exp, input string tag);
    addr = a; rdEn = 1'b1; evtIn = ev;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0; evtIn = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rdEvt(a, 8'h00, exp, tag);
  endtask

  task automatic pulse(input logic [7:0] ev);
    evtIn = ev;
    @(negedge clk);
    evtIn = '0;
  endtask

  always @(posedge clk) rdSeen <= rdEn;

  // Monitor: read data is due one edge after the strobe.
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R3 unexpected read actual=%0h expected=none", rdData);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdData", rdData, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 devMode", devMode, 0);
    check("R1 txStb", txStb, 0);
    check("R1 cfg", {gainCoef, mapCtl, muxSrc, muxDst, bIntEn, revBb, revBc, intMask}, 0);

    // R6 modes
    wr(0, 8'h21); wr(1, 8'h03);
    check("R6 power-down mode", devMode, 3);
    wr(0, 8'h21); wr(1, 8'h02);
    check("R6 data-only mode", devMode, 2);
    wr(0, 8'h21); wr(1, 8'hF9);
    check("R6 active mode", {intMask, devMode}, 3'b001);
    wr(0, 8'h21); rd(1, 8'h01, "R6 readback");

    // R2 direct locations
    rd(2, 8'hA1, "R2 loc2"); rd(3, 8'hB2, "R2 loc3"); rd(4, 8'hD4, "R2 loc4");
    rd(5, 8'hE5, "R2 loc5"); rd(6, 8'hF6, "R2 loc6"); rd(7, 8'hC3, "R2 loc7");
    wr(4, 8'h5A);
    check("R2 D strobe", {txStb, txByte}, {3'b001, 8'h5A});
    @(negedge clk);
    check("R2 strobe one cycle", txStb, 0);
    wr(6, 8'h3C);
    check("R2 Bc strobe", {txStb, txByte}, {3'b100, 8'h3C});
    wr(5, 8'h7E);
    check("R2 Bb strobe", {txStb, txByte}, {3'b010, 8'h7E});

    // R3 R4 R5 gain burst
    wr(0, 8'h63); wr(1, 8'h34); wr(1, 8'h12);
    check("R4 gain", gainCoef, 16'h1234);
    wr(1, 8'hFF);
    check("R5 gain past width", gainCoef, 16'h1234);
    wr(0, 8'h63);
    rd(1, 8'h34, "R4 low byte"); rd(1, 8'h12, "R4 high byte"); rd(1, 8'h00, "R5 read past width");
    // R3: a write after reads continues from the index
    wr(0, 8'h63); rd(1, 8'h34, "R3 index after read"); wr(1, 8'hAB);
    check("R3 index shared by read and write", gainCoef, 16'hAB34);

    // R8 R5 one-byte register
    wr(0, 8'h41); wr(1, 8'h43); wr(1, 8'h99);
    check("R8 mux codes", {muxDst, muxSrc}, 8'h43);
    wr(0, 8'h41); rd(1, 8'h43, "R5 mux second write ignored"); rd(1, 8'h00, "R5 mux second read");

    // R7
    wr(0, 8'h44); wr(1, 8'hFF);
    check("R7 enable bits", {bIntEn, revBb, revBc}, 3'b111);
    wr(0, 8'h44); rd(1, 8'h38, "R7 readback");

    // R9
    wr(0, 8'h69); wr(1, 8'h81);
    check("R9 map", {aLaw, mapCtl}, {1'b1, 8'h81});
    wr(0, 8'h69); rd(1, 8'h81, "R9 readback");
    wr(0, 8'h69); wr(1, 8'h80);
    check("R9 mu-law", aLaw, 0);

    // R13 unimplemented
    wr(0, 8'h22); wr(1, 8'h55);
    check("R13 no effect", {gainCoef, mapCtl, muxDst, muxSrc, bIntEn, revBb, revBc, intMask, devMode},
          {16'hAB34, 8'h80, 8'h43, 3'b111, 1'b0, 2'd1});
    wr(0, 8'h22); rd(1, 8'h00, "R13 read zero");
    wr(0, 8'h21); rd(1, 8'h01, "R13 init intact");

    // R10 R12 interrupts
    pulse(8'h05);
    check("R12 irq raised", irqOut, 1);
    rd(0, 8'h05, "R10 pending mask");
    check("R10 cleared", irqOut, 0);
    rdEvt(0, 8'h02, 8'h00, "R10 same-cycle read");
    check("R10 event kept", irqOut, 1);
    rd(0, 8'h02, "R10 kept bit");

    // R11
    wr(0, 8'h44); wr(1, 8'h00);
    pulse(8'h10);
    check("R11 blocked irq", irqOut, 0);
    rd(0, 8'h00, "R11 blocked mask");
    wr(0, 8'h44); wr(1, 8'h08);
    pulse(8'h10);
    check("R11 enabled irq", irqOut, 1);
    rd(0, 8'h10, "R11 enabled mask");

    // R12 gating
    wr(0, 8'h21); wr(1, 8'h05);
    pulse(8'h80);
    check("R12 masked", irqOut, 0);
    wr(0, 8'h21); wr(1, 8'h01);
    check("R12 unmasked keeps pending", irqOut, 1);
    wr(0, 8'h21); wr(1, 8'h00);
    check("R12 idle", irqOut, 0);
    rd(0, 8'h80, "R12 pending held");

    repeat (2) @(negedge clk);
    check("R3 reads drained", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule